// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Acknowledge

This block sits behind the register decoder of a small interrupt controller and does the per-CPU selection work. For each CPU it looks at every source that is both enabled and pending for that CPU and finds the source with the most urgent priority, where a smaller value is more urgent. It then checks that winner against the CPU's priority mask and the priority of the interrupt the CPU is already handling. The result drives one request line per CPU and a highest-pending identifier. The identifier value 1023 stands for "nothing".

CPUs take an interrupt through an acknowledge request, which returns the identifier one cycle later. They release it with an end-of-interrupt request. Preempted interrupts are kept in a per-CPU chain: each source holds a back-link to the interrupt that was running when it was taken. Completing the running interrupt falls back along that link. Completing an interrupt further down the chain removes it from the chain with a multi-cycle search. The block owns no pending storage. It emits a clear strobe on acknowledge and a set strobe on level re-assertion, and the surrounding logic applies both to the pending vector in the following cycle.

The acknowledge port is a valid/ready pair. A request is taken on a cycle where `ack_valid` and `ack_ready` are both high, and `rsp_valid` pulses exactly one cycle later with `rsp_id`. The response cannot be stalled. The end-of-interrupt port is also valid/ready. `eoi_ready` is low while a chain search runs and on any cycle where `ack_valid` is high, so an acknowledge always wins a same-cycle conflict. `ack_ready` is low only while a chain search runs.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Among sources with `src_en` set and the pending bit for this CPU set, the smallest priority value wins. On equal priority the lower source number wins. Pending bit for CPU c, source s is `pend[c*NSRC+s]`, and source s's priority is `prio[s*8 +: 8]`.
- R2: `hp_id` for a CPU shows the winner only when the winner's priority is at or below that CPU's mask; otherwise it shows 1023. A mask is written with `pm_wr` high, `pm_cpu` selecting the CPU and `pm_val` giving the value.
- R3: `irq[c]` is high only when a winner is shown on `hp_id` and its priority is strictly below that CPU's running priority. A winner of equal priority is shown on `hp_id` but leaves `irq` low.
- R4: When `glb_en` or `cpu_en[c]` is low, `irq[c]` is low and that CPU's `hp_id` reads 1023.
- R5: An acknowledge returns 1023 and leaves the running state unchanged when nothing is shown on `hp_id`, or when the shown source is not strictly more urgent than the running priority.
- R6: A successful acknowledge returns the source, makes it the running interrupt with its priority on `run_prio`, links the previous running ID behind it, and pulses `clr_valid` with `clr_id` equal to the source.
- R7: The clear mask is every CPU when `one_to_n[s]` is set, and only the acknowledging CPU otherwise.
- R8: An end-of-interrupt on a CPU with nothing running changes nothing and raises no set strobe.
- R9: Completing the running interrupt makes its back-link the running interrupt, with that source's priority. The idle priority is 0x100, carried on `run_prio` bit 8.
- R10: Completing an interrupt that is not running removes it from the chain, so later completions skip it.
- R11: On end-of-interrupt for source s, `set_valid` pulses with only the CPU's bit in `set_mask` when all of these hold: `edge_trig[s]` = 0, `src_en[s]` = 1, `line_hi[s]` = 1, and `target[c*NSRC+s]` = 1.
- R12: After reset the masks are 0xF0, `hp_id` is 1023, `run_prio` is 0x100 and `irq` is low.
- R13: A chain search holds `eoi_ready` and `ack_ready` low, starts only from an accepted end-of-interrupt, and ends within NSRC steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global forwarding enable |
| cpu_en | input | NCPU | Per-CPU interface enable |
| src_en | input | NSRC | Per-source enable |
| pend | input | NCPU*NSRC | Pending bits, CPU-major |
| prio | input | NSRC*PW | Per-source priority |
| one_to_n | input | NSRC | 1 = acknowledge clears pending on all CPUs |
| edge_trig | input | NSRC | 1 = edge triggered, 0 = level |
| line_hi | input | NSRC | Current level of each source line |
| target | input | NCPU*NSRC | Source routed to CPU, CPU-major |
| pm_wr | input | 1 | Priority mask write strobe |
| pm_cpu | input | CW | CPU selected by the mask write |
| pm_val | input | PW | New mask value |
| ack_valid | input | 1 | Acknowledge request |
| ack_cpu | input | CW | Requesting CPU |
| ack_ready | output | 1 | Acknowledge can be taken |
| rsp_valid | output | 1 | Acknowledge response pulse |
| rsp_id | output | 10 | Acknowledged ID or 1023 |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_cpu | input | CW | Completing CPU |
| eoi_id | input | 10 | Completed ID |
| eoi_ready | output | 1 | End-of-interrupt can be taken |
| irq | output | NCPU | Interrupt request per CPU |
| hp_id | output | NCPU*10 | Highest-pending ID per CPU |
| run_prio | output | NCPU*(PW+1) | Running priority per CPU |
| clr_valid | output | 1 | Pending clear strobe |
| clr_id | output | 10 | Source to clear |
| clr_mask | output | NCPU | CPUs to clear |
| set_valid | output | 1 | Pending set strobe (level re-assert) |
| set_id | output | 10 | Source to set |
| set_mask | output | NCPU | CPU to set |

## Verification
The assertions take for granted that the pending vector only changes through the environment, and that the clear and set strobes are applied in the cycle after they pulse. They also take for granted that `ack_cpu` and `eoi_cpu` name an existing CPU and that `eoi_id` is a real source or 1023. The stimulus changes inputs on the falling edge and routes every pending change through a one-cycle set strobe in the bench's pending store. It then waits several cycles before each acknowledge, so the registered `hp_id` reflects the latest pending state. It never raises `ack_valid` and `eoi_valid` together, and it waits for `eoi_ready` after every completion.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int          ID_W     = 10;
  localparam logic [9:0]  ID_NONE  = 10'd1023;
  localparam logic [7:0]  MASK_RST = 8'hF0;
endpackage

// File: rtl/irqsel_scan.sv
module irqsel_scan
  import irqsel_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = 8
) (
  input  logic [NSRC-1:0]    live,
  input  logic [NSRC*PW-1:0] prio,
  output logic [PW:0]        best_p,
  output logic [ID_W-1:0]    best_id
);
  localparam int LVL = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int N2  = 1 << LVL;
  localparam logic [PW:0] P_NONE = {1'b1, {PW{1'b0}}};

  // heap-ordered comparison tree, node 1 is the root
  logic [2*N2-1:0][PW:0]      np;
  logic [2*N2-1:0][ID_W-1:0]  ni;

  assign np[0] = '0;
  assign ni[0] = '0;

  for (genvar i = 0; i < N2; i++) begin : g_leaf
    if (i < NSRC) begin : g_real
      assign np[N2+i] = live[i] ? {1'b0, prio[i*PW +: PW]} : P_NONE;
      assign ni[N2+i] = live[i] ? ID_W'(i) : ID_NONE;
    end else begin : g_pad
      assign np[N2+i] = P_NONE;
      assign ni[N2+i] = ID_NONE;
    end
  end

  // right child replaces left only when strictly more urgent
  for (genvar k = 1; k < N2; k++) begin : g_node
    logic take_r;
    assign take_r = np[2*k+1] < np[2*k];
    assign np[k]  = take_r ? np[2*k+1] : np[2*k];
    assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
  end

  assign best_p  = np[1];
  assign best_id = ni[1];

  always_comb begin
    if (best_id != ID_NONE)
      p_winner_live_r1: assert (live[best_id[LVL-1:0]])
        else $error("winner is not enabled and pending");
  end
endmodule

// File: rtl/irqsel_gate.sv
module irqsel_gate
  import irqsel_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            pm_we,
  input  logic [PW-1:0]   pm_val,
  input  logic [PW:0]     best_p,
  input  logic [ID_W-1:0] best_id,
  input  logic [PW:0]     run_p,
  output logic [ID_W-1:0] hp_id,
  output logic [PW:0]     hp_p,
  output logic            irq
);
  localparam logic [PW:0] P_NONE = {1'b1, {PW{1'b0}}};

  logic [PW-1:0] pmask;
  logic          hp_ok;

  assign hp_ok = en && (best_p <= {1'b0, pmask});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask <= PW'(MASK_RST);
      hp_id <= ID_NONE;
      hp_p  <= P_NONE;
      irq   <= 1'b0;
    end else begin
      if (pm_we) pmask <= pm_val;
      hp_id <= hp_ok ? best_id : ID_NONE;
      hp_p  <= hp_ok ? best_p  : P_NONE;
      irq   <= hp_ok && (best_p < run_p);
    end
  end

  p_hp_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_id != ID_NONE) |-> (hp_p <= {1'b0, $past(pmask)}));

  p_irq_needs_hp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((hp_id != ID_NONE) && (hp_p < $past(run_p))));

  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!irq && (hp_id == ID_NONE)));
endmodule

// File: rtl/irqsel_chain.sv
module irqsel_chain
  import irqsel_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NCPU = 2,
  parameter int PW   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCPU*ID_W-1:0]      hp_id_all,
  input  logic [NCPU*(PW+1)-1:0]    hp_p_all,
  input  logic [NSRC*PW-1:0]        prio,
  input  logic [NSRC-1:0]           one_to_n,
  input  logic [NSRC-1:0]           edge_trig,
  input  logic [NSRC-1:0]           line_hi,
  input  logic [NSRC-1:0]           src_en,
  input  logic [NCPU*NSRC-1:0]      target,
  input  logic                      ack_valid,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] ack_cpu,
  output logic                      ack_ready,
  output logic                      rsp_valid,
  output logic [ID_W-1:0]           rsp_id,
  input  logic                      eoi_valid,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] eoi_cpu,
  input  logic [ID_W-1:0]           eoi_id,
  output logic                      eoi_ready,
  output logic [NCPU*(PW+1)-1:0]    run_p_all,
  output logic                      clr_valid,
  output logic [ID_W-1:0]           clr_id,
  output logic [NCPU-1:0]           clr_mask,
  output logic                      set_valid,
  output logic [ID_W-1:0]           set_id,
  output logic [NCPU-1:0]           set_mask
);
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [PW:0] P_NONE = {1'b1, {PW{1'b0}}};

  logic [NCPU-1:0][ID_W-1:0] hp_id_v;
  logic [NCPU-1:0][PW:0]     hp_p_v;
  logic [NCPU-1:0][NSRC-1:0] tgt_v;
  assign hp_id_v = hp_id_all;
  assign hp_p_v  = hp_p_all;
  assign tgt_v   = target;

  // per CPU, per source: ID that was running when the source was taken
  logic [ID_W-1:0] lnk [NCPU][NSRC];
  logic [NCPU-1:0][ID_W-1:0] run_id_q;
  logic [NCPU-1:0][PW:0]     run_p_q;
  assign run_p_all = run_p_q;

  // chain search state
  logic            busy;
  logic [CW-1:0]   w_cpu;
  logic [ID_W-1:0] w_cur, w_tgt, w_cnt;

  function automatic logic [PW:0] prio_of(input logic [ID_W-1:0] id,
                                          input logic [NSRC*PW-1:0] pv);
    if (id == ID_NONE || id >= ID_W'(NSRC)) return P_NONE;
    return {1'b0, pv[id*PW +: PW]};
  endfunction

  logic            ack_go, eoi_go, a_hit, e_rmk, e_inr;
  logic [ID_W-1:0] a_id, e_run, e_back, w_nxt, w_skip;
  logic [PW:0]     a_p;
  logic [IW-1:0]   e_idx;
  logic [NCPU-1:0] ack_bit, eoi_bit;

  always_comb begin
    ack_ready = !busy;
    eoi_ready = !busy && !ack_valid;
    ack_go    = ack_valid && ack_ready;
    eoi_go    = eoi_valid && eoi_ready;
    a_id      = hp_id_v[ack_cpu];
    a_p       = hp_p_v[ack_cpu];
    a_hit     = (a_id != ID_NONE) && (a_p < run_p_q[ack_cpu]);
    ack_bit   = NCPU'(1) << ack_cpu;
    eoi_bit   = NCPU'(1) << eoi_cpu;
    e_run     = run_id_q[eoi_cpu];
    e_idx     = eoi_id[IW-1:0];
    e_inr     = eoi_id < ID_W'(NSRC);
    e_rmk     = e_inr && !edge_trig[e_idx] && src_en[e_idx] &&
                line_hi[e_idx] && tgt_v[eoi_cpu][e_idx];
    e_back    = lnk[eoi_cpu][e_run[IW-1:0]];
    w_nxt     = lnk[w_cpu][w_cur[IW-1:0]];
    w_skip    = lnk[w_cpu][w_tgt[IW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin
        run_id_q[c] <= ID_NONE;
        run_p_q[c]  <= P_NONE;
        for (int s = 0; s < NSRC; s++) lnk[c][s] <= ID_NONE;
      end
      rsp_valid <= 1'b0;
      rsp_id    <= ID_NONE;
      clr_valid <= 1'b0;
      clr_id    <= ID_NONE;
      clr_mask  <= '0;
      set_valid <= 1'b0;
      set_id    <= ID_NONE;
      set_mask  <= '0;
      busy      <= 1'b0;
      w_cpu     <= '0;
      w_cur     <= ID_NONE;
      w_tgt     <= ID_NONE;
      w_cnt     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      clr_valid <= 1'b0;
      set_valid <= 1'b0;

      if (ack_go) begin
        rsp_valid <= 1'b1;
        if (a_hit) begin
          rsp_id                       <= a_id;
          lnk[ack_cpu][a_id[IW-1:0]]   <= run_id_q[ack_cpu];
          run_id_q[ack_cpu]            <= a_id;
          run_p_q[ack_cpu]             <= a_p;
          clr_valid                    <= 1'b1;
          clr_id                       <= a_id;
          clr_mask                     <= one_to_n[a_id[IW-1:0]] ? '1 : ack_bit;
        end else begin
          rsp_id <= ID_NONE;
        end
      end

      if (eoi_go && (e_run != ID_NONE)) begin
        if (e_rmk) begin
          set_valid <= 1'b1;
          set_id    <= eoi_id;
          set_mask  <= eoi_bit;
        end
        if (eoi_id == e_run) begin
          run_id_q[eoi_cpu] <= e_back;
          run_p_q[eoi_cpu]  <= prio_of(e_back, prio);
        end else begin
          busy  <= 1'b1;
          w_cpu <= eoi_cpu;
          w_cur <= e_run;
          w_tgt <= eoi_id;
          w_cnt <= '0;
        end
      end

      if (busy) begin
        if (w_nxt == ID_NONE || w_cnt == ID_W'(NSRC - 1)) begin
          busy <= 1'b0;
        end else if (w_nxt == w_tgt) begin
          lnk[w_cpu][w_cur[IW-1:0]] <= w_skip;
          busy <= 1'b0;
        end else begin
          w_cur <= w_nxt;
          w_cnt <= w_cnt + 1'b1;
        end
      end
    end
  end

  p_miss_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_id == ID_NONE) |-> $stable(run_id_q));

  p_hit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_id != ID_NONE) |-> (clr_valid && clr_id == rsp_id));

  p_idle_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_go && e_run == ID_NONE) |=> (!set_valid && $stable(run_id_q)));

  p_remark_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> ($countones(set_mask) == 1));

  p_walk_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(eoi_valid));

  p_walk_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (w_cnt < ID_W'(NSRC)));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irqsel_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NCPU = 2,
  parameter int PW   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      glb_en,
  input  logic [NCPU-1:0]           cpu_en,
  input  logic [NSRC-1:0]           src_en,
  input  logic [NCPU*NSRC-1:0]      pend,
  input  logic [NSRC*PW-1:0]        prio,
  input  logic [NSRC-1:0]           one_to_n,
  input  logic [NSRC-1:0]           edge_trig,
  input  logic [NSRC-1:0]           line_hi,
  input  logic [NCPU*NSRC-1:0]      target,
  input  logic                      pm_wr,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] pm_cpu,
  input  logic [PW-1:0]             pm_val,
  input  logic                      ack_valid,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] ack_cpu,
  output logic                      ack_ready,
  output logic                      rsp_valid,
  output logic [9:0]                rsp_id,
  input  logic                      eoi_valid,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] eoi_cpu,
  input  logic [9:0]                eoi_id,
  output logic                      eoi_ready,
  output logic [NCPU-1:0]           irq,
  output logic [NCPU*10-1:0]        hp_id,
  output logic [NCPU*(PW+1)-1:0]    run_prio,
  output logic                      clr_valid,
  output logic [9:0]                clr_id,
  output logic [NCPU-1:0]           clr_mask,
  output logic                      set_valid,
  output logic [9:0]                set_id,
  output logic [NCPU-1:0]           set_mask
);
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic [NCPU*(PW+1)-1:0] hp_p_all;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NSRC-1:0] live;
    logic [PW:0]     bp;
    logic [ID_W-1:0] bi;
    assign live = src_en & pend[c*NSRC +: NSRC];

    irqsel_scan #(.NSRC(NSRC), .PW(PW)) u_scan (
      .live    (live),
      .prio    (prio),
      .best_p  (bp),
      .best_id (bi)
    );

    irqsel_gate #(.PW(PW)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (glb_en & cpu_en[c]),
      .pm_we   (pm_wr && (pm_cpu == CW'(c))),
      .pm_val  (pm_val),
      .best_p  (bp),
      .best_id (bi),
      .run_p   (run_prio[c*(PW+1) +: (PW+1)]),
      .hp_id   (hp_id[c*ID_W +: ID_W]),
      .hp_p    (hp_p_all[c*(PW+1) +: (PW+1)]),
      .irq     (irq[c])
    );
  end

  irqsel_chain #(.NSRC(NSRC), .NCPU(NCPU), .PW(PW)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .hp_id_all (hp_id),
    .hp_p_all  (hp_p_all),
    .prio      (prio),
    .one_to_n  (one_to_n),
    .edge_trig (edge_trig),
    .line_hi   (line_hi),
    .src_en    (src_en),
    .target    (target),
    .ack_valid (ack_valid),
    .ack_cpu   (ack_cpu),
    .ack_ready (ack_ready),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .eoi_valid (eoi_valid),
    .eoi_cpu   (eoi_cpu),
    .eoi_id    (eoi_id),
    .eoi_ready (eoi_ready),
    .run_p_all (run_prio),
    .clr_valid (clr_valid),
    .clr_id    (clr_id),
    .clr_mask  (clr_mask),
    .set_valid (set_valid),
    .set_id    (set_id),
    .set_mask  (set_mask)
  );
endmodule

// File: tb/sim_irq_prio_arbiter.sv
`timescale 1ns/1ps
module sim_irq_prio_arbiter;
  localparam int NS = 64;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           glb_en = 0;
  logic [NC-1:0]  cpu_en = '0;
  logic [NS-1:0]  src_en = '0, one_to_n = '0, edge_trig = '0, line_hi = '0;
  logic [NC*NS-1:0] pend, target = '0, sw_set = '0, pend_m = '0;
  logic [NS*8-1:0] prio = '0;
  logic           pm_wr = 0, pm_cpu = 0;
  logic [7:0]     pm_val = '0;
  logic           ack_valid = 0, ack_cpu = 0, ack_ready, rsp_valid;
  logic [9:0]     rsp_id;
  logic           eoi_valid = 0, eoi_cpu = 0, eoi_ready;
  logic [9:0]     eoi_id = '0;
  logic [NC-1:0]  irq, clr_mask, set_mask;
  logic [NC*10-1:0] hp_id;
  logic [NC*9-1:0]  run_prio;
  logic           clr_valid, set_valid;
  logic [9:0]     clr_id, set_id;

  irq_prio_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cpu_en(cpu_en),
    .src_en(src_en), .pend(pend), .prio(prio), .one_to_n(one_to_n),
    .edge_trig(edge_trig), .line_hi(line_hi), .target(target),
    .pm_wr(pm_wr), .pm_cpu(pm_cpu), .pm_val(pm_val),
    .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_ready(ack_ready),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
    .eoi_ready(eoi_ready), .irq(irq), .hp_id(hp_id), .run_prio(run_prio),
    .clr_valid(clr_valid), .clr_id(clr_id), .clr_mask(clr_mask),
    .set_valid(set_valid), .set_id(set_id), .set_mask(set_mask)
  );

  // environment pending store: applies strobes one cycle after they pulse
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else begin
      logic [NC*NS-1:0] nx;
      nx = pend | sw_set;
      for (int c = 0; c < NC; c++) begin
        if (clr_valid && clr_mask[c]) nx[c*NS + clr_id] = 1'b0;
        if (set_valid && set_mask[c]) nx[c*NS + set_id] = 1'b1;
      end
      pend <= nx;
    end
  end

  int total = 0, bad = 0;
  int exp_q[$];
  int stk[2][$];
  int pm_m[2] = '{240, 240};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor for acknowledge responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5/R6 unexpected response", rsp_id, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(rsp_id == e, "R5/R6 ack id", rsp_id, e);
      end
    end
  end

  function automatic int pr(int s); return prio[s*8 +: 8]; endfunction
  function automatic int runp(int c);
    if (stk[c].size() == 0) return 256;
    return pr(stk[c][stk[c].size()-1]);
  endfunction
  function automatic int ref_best(int c);
    int bp, bi;
    bp = 256; bi = 1023;
    if (!glb_en || !cpu_en[c]) return 1023;
    for (int s = 0; s < NS; s++)
      if (src_en[s] && pend_m[c*NS+s] && pr(s) < bp) begin bp = pr(s); bi = s; end
    if (bp > pm_m[c]) return 1023;
    return bi;
  endfunction
  function automatic int hp(int c); return hp_id[c*10 +: 10]; endfunction
  function automatic int rp(int c); return run_prio[c*9 +: 9]; endfunction

  task automatic settle(); repeat (4) @(negedge clk); endtask
  task automatic raise(input int c, input int s);
    @(negedge clk); sw_set[c*NS+s] = 1'b1; pend_m[c*NS+s] = 1'b1;
    @(negedge clk); sw_set = '0;
  endtask
  task automatic setmask(input int c, input int v);
    @(negedge clk); pm_wr = 1; pm_cpu = c[0]; pm_val = v[7:0]; pm_m[c] = v;
    @(negedge clk); pm_wr = 0;
  endtask
  task automatic do_ack(input int c);
    int b, e;
    settle();
    b = ref_best(c);
    e = 1023;
    if (b != 1023 && pr(b) < runp(c)) begin
      e = b;
      stk[c].push_back(b);
      for (int k = 0; k < NC; k++)
        if (one_to_n[b] || k == c) pend_m[k*NS+b] = 1'b0;
    end
    exp_q.push_back(e);
    chk(ack_ready == 1'b1, "R13 ack_ready idle", ack_ready, 1);
    ack_valid = 1; ack_cpu = c[0];
    @(negedge clk); ack_valid = 0;
    settle();
    chk(pend == pend_m, "R7 pending after ack", 0, 1);
  endtask
  task automatic do_eoi(input int c, input int id);
    bit walk;
    walk = 0;
    if (stk[c].size() != 0) begin
      if (id < NS && !edge_trig[id] && src_en[id] && line_hi[id] && target[c*NS+id])
        pend_m[c*NS+id] = 1'b1;
      if (id == stk[c][stk[c].size()-1]) void'(stk[c].pop_back());
      else begin
        walk = 1;
        for (int k = 0; k < stk[c].size()-1; k++)
          if (stk[c][k] == id) begin stk[c].delete(k); break; end
      end
    end
    @(negedge clk); eoi_valid = 1; eoi_cpu = c[0]; eoi_id = id[9:0];
    @(negedge clk); eoi_valid = 0;
    if (walk) chk(!eoi_ready && !ack_ready, "R13 ready low while walking", eoi_ready, 0);
    for (int i = 0; i < 200 && !eoi_ready; i++) @(negedge clk);
    settle();
    chk(pend == pend_m, "R11 pending after eoi", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) prio[s*8 +: 8] = 8'hA0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(hp(0) == 1023 && hp(1) == 1023, "R12 hp_id reset", hp(0), 1023);
    chk(rp(0) == 256 && rp(1) == 256, "R12 run_prio reset", rp(0), 256);
    chk(irq == 2'b00 && ack_ready && eoi_ready, "R12 irq/ready reset", irq, 0);

    // R12 default mask 0xF0 boundary, R4 enables
    src_en = '1; target = '1;
    prio[50*8 +: 8] = 8'hF1;
    raise(0, 50); settle();
    chk(hp(0) == 1023, "R4 global off", hp(0), 1023);
    glb_en = 1; cpu_en = 2'b11; settle();
    chk(hp(0) == 1023, "R12 mask rejects 0xF1", hp(0), 1023);
    @(negedge clk); prio[50*8 +: 8] = 8'hF0; settle();
    chk(hp(0) == 50 && irq[0], "R12 mask accepts 0xF0", hp(0), 50);
    @(negedge clk); cpu_en = 2'b10; settle();
    chk(hp(0) == 1023 && !irq[0], "R4 cpu off", hp(0), 1023);
    @(negedge clk); cpu_en = 2'b11; src_en[50] = 0;

    // R1 priority and tie-break
    @(negedge clk);
    prio[5*8 +: 8] = 8'h40; prio[9*8 +: 8] = 8'h20; prio[12*8 +: 8] = 8'h20;
    raise(0, 12); raise(0, 5); raise(0, 9); settle();
    chk(hp(0) == 9 && hp(0) == ref_best(0), "R1 lowest value, lowest id", hp(0), 9);
    chk(irq[0] == 1'b1, "R3 irq raised", irq[0], 1);

    // R2 mask
    setmask(0, 8'h10); settle();
    chk(hp(0) == 1023 && !irq[0], "R2 masked winner", hp(0), 1023);
    setmask(0, 8'hF0);

    // R6 acknowledge, R3 equal priority holds irq low
    do_ack(0);
    chk(rp(0) == 8'h20, "R6 running prio", rp(0), 32);
    chk(hp(0) == 12 && !irq[0], "R3 equal prio no irq", irq[0], 0);
    // R5 non-eligible acknowledge
    do_ack(0);
    chk(rp(0) == 8'h20, "R5 state kept", rp(0), 32);

    // nest two more
    @(negedge clk); prio[3*8 +: 8] = 8'h10; prio[1*8 +: 8] = 8'h05;
    raise(0, 3); do_ack(0);
    raise(0, 1); do_ack(0);
    chk(rp(0) == 5, "R6 nested running prio", rp(0), 5);

    // R10 splice bottom of chain, R9 restore
    do_eoi(0, 9);
    do_eoi(0, 1);
    chk(rp(0) == 8'h10, "R9 back-link restore", rp(0), 16);
    do_eoi(0, 3);
    chk(rp(0) == 256, "R10 spliced source skipped", rp(0), 256);

    // R7 one-to-N versus N-to-N clear
    @(negedge clk); one_to_n[12] = 1; prio[30*8 +: 8] = 8'h08;
    raise(1, 12); do_ack(1);
    chk(pend[12] == 0 && pend[NS+12] == 0, "R7 1:N clears all", pend[12], 0);
    raise(0, 30); raise(1, 30); do_ack(1);
    chk(pend[30] == 1 && pend[NS+30] == 0, "R7 N:N clears own", pend[30], 1);
    do_ack(0);
    do_eoi(1, 30); do_eoi(1, 12); do_eoi(0, 30);
    chk(rp(0) == 256 && rp(1) == 256, "R9 chains empty", rp(1), 256);

    // R8 idle completion ignored
    @(negedge clk); prio[40*8 +: 8] = 8'h30; line_hi[40] = 1;
    do_eoi(0, 40);
    chk(pend[40] == 0 && rp(0) == 256, "R8 idle eoi ignored", pend[40], 0);

    // R11 level re-assert
    raise(0, 40); do_ack(0);
    chk(pend[40] == 0, "R11 cleared on ack", pend[40], 0);
    do_eoi(0, 40);
    chk(pend[40] == 1 && hp(0) == 40, "R11 level re-marked", pend[40], 1);
    do_ack(0);
    @(negedge clk); target[40] = 0;
    do_eoi(0, 40);
    chk(pend[40] == 0 && set_valid == 0, "R11 not targeted no re-mark", pend[40], 0);

    chk(exp_q.size() == 0, "R6 all responses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule